// File: doc/BRIEF.md
# Three-Wire Byte Handshake Engine

This block moves a packet between a host processor and a controller one byte at a time over three active-low strobes. The host drives a transfer-in-progress line and a transfer-acknowledge line through writes to a port register. The engine drives a transfer-request line back to the host. An auxiliary-control direction bit selects the direction. When the host sends, every change in the strobe pair copies the shift register into the next slot of a capture buffer. When the host receives, every change presents the next byte of a reply packet in the shift register.

Each byte step pulses a shift-register event, which the surrounding interrupt logic latches. At the end of an outgoing transfer the engine issues a packet-complete pulse that carries the byte count. A downstream decoder then reads the captured bytes through a random-access port. While no transfer is running, acknowledge toggles are echoed onto the request line so both sides can resynchronise. Pending reply bytes hold the request line low to ask for the host's attention. Every decision is taken only in a cycle that writes the port strobes, writes the direction, or loads a reply. All outputs are registered and change one clock after that cycle.

Top module: `hs_byte_engine`

## Requirements
- R1: After reset, treq_n is 1, sr_q is 0, and sr_set and pkt_done are 0; the idle strobe state is in-progress=1 and acknowledge=1.
- R2: With direction 1 (host sends) and in-progress low (0), any write that changes the {in-progress, acknowledge} pair stores sr_q into the next capture slot, starting at slot 0, and pulses sr_set one clock later; the slot contents are readable on cap_rdata at cap_raddr.
- R3: Once OUT_DEPTH bytes are captured, further pair changes in the same transfer store nothing and give no sr_set pulse; the reported count is then OUT_DEPTH.
- R4: With direction 0 (host receives), in-progress low and reply bytes remaining, any pair change loads the next reply byte into sr_q, in index order from 0, and pulses sr_set.
- R5: The step that loads the last reply byte drives treq_n to 1.
- R6: A strobe write that leaves the pair unchanged while in-progress is low neither stores, loads nor pulses sr_set.
- R7: With in-progress high both before and after a write that changes acknowledge, treq_n takes the new acknowledge level and sr_set pulses.
- R8: A write that raises in-progress from 0 to 1 always pulses sr_set; if at least one byte was captured, it also pulses pkt_done with pkt_len equal to the count and restarts capture at slot 0.
- R9: In any evaluation with in-progress high that is not an acknowledge echo (R7), pending reply bytes drive treq_n to 0.
- R10: rep_load sets the reply length to rep_len (limited to IN_DEPTH) and the read index to 0, and pulses sr_set.
- R11: A direction write is an evaluation; in the idle state, with reply bytes pending, it drives treq_n to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_wr | input | 1 | Host write of the strobe lines |
| pb_tip_n | input | 1 | Written transfer-in-progress level (active low) |
| pb_tack_n | input | 1 | Written acknowledge level (active low) |
| acr_wr | input | 1 | Host write of the direction bit |
| acr_dir | input | 1 | Written direction, 1 = host sends |
| sr_wr | input | 1 | Host write of the shift register |
| sr_wdata | input | W | Shift register write data |
| rep_wr | input | 1 | Write one reply buffer byte |
| rep_waddr | input | log2(IN_DEPTH) | Reply buffer write address |
| rep_wdata | input | W | Reply buffer write data |
| rep_load | input | 1 | Arm a reply packet of rep_len bytes |
| rep_len | input | log2(IN_DEPTH+1) | Reply packet length |
| cap_raddr | input | log2(OUT_DEPTH) | Capture buffer read address |
| cap_rdata | output | W | Capture buffer read data |
| sr_q | output | W | Shift register contents |
| treq_n | output | 1 | Transfer-request line (active low) |
| sr_set | output | 1 | One-cycle shift-register event pulse |
| pkt_done | output | 1 | One-cycle packet-complete pulse |
| pkt_len | output | log2(OUT_DEPTH+1) | Byte count of the last completed packet |

## Verification
A wrong byte index shows up at once as a wrong sr_q after a receive step or a wrong cap_rdata value. It also shows one step later as a missing or extra sr_set pulse, or as treq_n rising too early or too late. A wrong stored strobe level turns an edge into a non-edge: the missing or extra sr_set pulse appears in the very next clock. The reference model follows each write separately, so the bench reports such errors in the cycle they occur. A wrong capture count surfaces only at the next rise of in-progress, as a wrong pkt_len or a missing pkt_done.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // Actions decided in one evaluation cycle.
  typedef struct packed {
    logic cap;      // store shift register into capture buffer
    logic fetch;    // load next reply byte into shift register
    logic flag;     // shift-register event
    logic fire;     // packet complete
    logic treq_hi;  // release request line
    logic treq_lo;  // assert request line
    logic treq_cp;  // echo acknowledge onto request line
  } hs_act_t;
endpackage

// File: rtl/hs_ctl.sv
module hs_ctl
  import hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    eval,
  input  logic    pb_wr,
  input  logic    pb_tip_n,
  input  logic    pb_tack_n,
  input  logic    dir_out,
  input  logic    out_room,
  input  logic    out_nz,
  input  logic    in_pend,
  input  logic    in_last,
  output hs_act_t act,
  output logic    cur_tack
);

  logic last_tip_q, last_tack_q;
  logic tip_c, tack_c, pair_chg;

  always_comb begin
    tip_c    = pb_wr ? pb_tip_n  : last_tip_q;
    tack_c   = pb_wr ? pb_tack_n : last_tack_q;
    pair_chg = (tip_c ^ last_tip_q) | (tack_c ^ last_tack_q);
    cur_tack = tack_c;
  end

  always_comb begin
    act = '0;
    if (eval) begin
      if (!tip_c) begin
        if (dir_out) begin
          if (pair_chg && out_room) begin
            act.cap  = 1'b1;
            act.flag = 1'b1;
          end
        end else if (pair_chg && in_pend) begin
          act.fetch   = 1'b1;
          act.flag    = 1'b1;
          act.treq_hi = in_last;
        end
      end else if (last_tip_q && (tack_c != last_tack_q)) begin
        act.treq_cp = 1'b1;
        act.flag    = 1'b1;
      end else begin
        if (!last_tip_q) begin
          act.flag = 1'b1;
          act.fire = out_nz;
        end
        act.treq_lo = in_pend;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_tip_q  <= 1'b1;
      last_tack_q <= 1'b1;
    end else if (eval) begin
      last_tip_q  <= tip_c;
      last_tack_q <= tack_c;
    end
  end

  // R6: no change of the pair while active gives no byte step
  p_no_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !tip_c && !pair_chg) |-> !(act.cap || act.fetch));

endmodule

// File: rtl/hs_cap_buf.sv
module hs_cap_buf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          clr,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic          room,
  output logic          nz,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  mem_q [DEPTH];

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (cap) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || cap) cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem_q[g] <= '0;
      else if (cap && (cnt_q == CW'(g)))    mem_q[g] <= din;
    end
  end

  assign rdata = mem_q[raddr];
  assign room  = (cnt_q < CW'(DEPTH));
  assign nz    = (cnt_q != '0);
  assign cnt   = cnt_q;

  // R3: the count never passes the buffer depth
  p_cap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R2: each capture advances the slot by exactly one
  p_cap_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !clr) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/hs_rep_buf.sv
module hs_rep_buf #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W     = 8,
  localparam int unsigned LW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          load,
  input  logic [LW-1:0] len,
  input  logic          fetch,
  output logic          pend,
  output logic          last,
  output logic [W-1:0]  rbyte
);

  logic [LW-1:0] idx_q, size_q;
  logic [LW-1:0] eff_idx, eff_size, len_c, idx_d;
  logic [W-1:0]  mem_q [DEPTH];

  always_comb begin
    len_c    = (len > LW'(DEPTH)) ? LW'(DEPTH) : len;
    eff_idx  = load ? '0 : idx_q;
    eff_size = load ? len_c : size_q;
    idx_d    = eff_idx + LW'(fetch);
  end

  assign pend  = (eff_idx < eff_size);
  assign last  = ({1'b0, eff_idx} + (LW + 1)'(1)) >= {1'b0, eff_size};
  assign rbyte = mem_q[eff_idx[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      size_q <= '0;
    end else if (load || fetch) begin
      idx_q  <= idx_d;
      size_q <= eff_size;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem_q[g] <= '0;
      else if (wr && (waddr == AW'(g)))    mem_q[g] <= wdata;
    end
  end

  // R4: the read index never passes the armed length
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= size_q);

  // R4: a byte is only fetched while one remains
  p_fetch_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> pend);

  // R10: arming restarts the read index
  p_load_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !fetch) |=> (idx_q == '0));

endmodule

// File: rtl/hs_byte_engine.sv
module hs_byte_engine
  import hs_pkg::*;
#(
  parameter int unsigned OUT_DEPTH = 16,
  parameter int unsigned IN_DEPTH  = 128,
  parameter int unsigned W         = 8,
  localparam int unsigned CW  = $clog2(OUT_DEPTH + 1),
  localparam int unsigned OAW = $clog2(OUT_DEPTH),
  localparam int unsigned LW  = $clog2(IN_DEPTH + 1),
  localparam int unsigned IAW = $clog2(IN_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pb_wr,
  input  logic           pb_tip_n,
  input  logic           pb_tack_n,
  input  logic           acr_wr,
  input  logic           acr_dir,
  input  logic           sr_wr,
  input  logic [W-1:0]   sr_wdata,
  input  logic           rep_wr,
  input  logic [IAW-1:0] rep_waddr,
  input  logic [W-1:0]   rep_wdata,
  input  logic           rep_load,
  input  logic [LW-1:0]  rep_len,
  input  logic [OAW-1:0] cap_raddr,
  output logic [W-1:0]   cap_rdata,
  output logic [W-1:0]   sr_q,
  output logic           treq_n,
  output logic           sr_set,
  output logic           pkt_done,
  output logic [CW-1:0]  pkt_len
);

  hs_act_t       act;
  logic          eval, dir_q, dir_c, cur_tack;
  logic          out_room, out_nz, in_pend, in_last;
  logic [CW-1:0] cap_cnt;
  logic [W-1:0]  rep_byte;

  logic [W-1:0]  sr_r, sr_d;
  logic          treq_r, treq_d, set_r, done_r;
  logic [CW-1:0] len_r;

  assign eval  = pb_wr | acr_wr | rep_load;
  assign dir_c = acr_wr ? acr_dir : dir_q;

  hs_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval      (eval),
    .pb_wr     (pb_wr),
    .pb_tip_n  (pb_tip_n),
    .pb_tack_n (pb_tack_n),
    .dir_out   (dir_c),
    .out_room  (out_room),
    .out_nz    (out_nz),
    .in_pend   (in_pend),
    .in_last   (in_last),
    .act       (act),
    .cur_tack  (cur_tack)
  );

  hs_cap_buf #(.DEPTH(OUT_DEPTH), .W(W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (act.cap),
    .clr   (act.fire),
    .din   (sr_r),
    .raddr (cap_raddr),
    .rdata (cap_rdata),
    .room  (out_room),
    .nz    (out_nz),
    .cnt   (cap_cnt)
  );

  hs_rep_buf #(.DEPTH(IN_DEPTH), .W(W)) u_rep (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (rep_wr),
    .waddr (rep_waddr),
    .wdata (rep_wdata),
    .load  (rep_load),
    .len   (rep_len),
    .fetch (act.fetch),
    .pend  (in_pend),
    .last  (in_last),
    .rbyte (rep_byte)
  );

  always_comb begin
    treq_d = treq_r;
    if (act.treq_hi)      treq_d = 1'b1;
    else if (act.treq_lo) treq_d = 1'b0;
    else if (act.treq_cp) treq_d = cur_tack;
    sr_d = sr_r;
    if (act.fetch)        sr_d = rep_byte;
    else if (sr_wr)       sr_d = sr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      sr_r   <= '0;
      treq_r <= 1'b1;
      set_r  <= 1'b0;
      done_r <= 1'b0;
      len_r  <= '0;
    end else begin
      if (acr_wr)                dir_q  <= acr_dir;
      if (act.fetch || sr_wr)    sr_r   <= sr_d;
      if (eval)                  treq_r <= treq_d;
      set_r  <= act.flag | rep_load;
      done_r <= act.fire;
      if (act.fire)              len_r  <= cap_cnt;
    end
  end

  assign sr_q     = sr_r;
  assign treq_n   = treq_r;
  assign sr_set   = set_r;
  assign pkt_done = done_r;
  assign pkt_len  = len_r;

  // R8: a completed packet always comes with an event pulse
  p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> sr_set);

  // R8: a completed packet never reports zero bytes
  p_done_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_len != '0));

  // R5: loading the last reply byte releases the request line
  p_last_treq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act.fetch && in_last) |=> treq_n);

  // R10: arming a reply always gives an event pulse
  p_load_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rep_load |=> sr_set);

endmodule

// File: tb/sim_hs_byte_engine.sv
module sim_hs_byte_engine;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pb_wr = 0, pb_tip_n = 1, pb_tack_n = 1;
  logic       acr_wr = 0, acr_dir = 0;
  logic       sr_wr = 0;
  logic [7:0] sr_wdata = 0;
  logic       rep_wr = 0;
  logic [6:0] rep_waddr = 0;
  logic [7:0] rep_wdata = 0;
  logic       rep_load = 0;
  logic [7:0] rep_len = 0;
  logic [3:0] cap_raddr = 0;
  logic [7:0] cap_rdata, sr_q;
  logic       treq_n, sr_set, pkt_done;
  logic [4:0] pkt_len;

  int nchk = 0, nbad = 0;

  hs_byte_engine u0 (
    .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_tip_n(pb_tip_n),
    .pb_tack_n(pb_tack_n), .acr_wr(acr_wr), .acr_dir(acr_dir),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .rep_wr(rep_wr),
    .rep_waddr(rep_waddr), .rep_wdata(rep_wdata), .rep_load(rep_load),
    .rep_len(rep_len), .cap_raddr(cap_raddr), .cap_rdata(cap_rdata),
    .sr_q(sr_q), .treq_n(treq_n), .sr_set(sr_set), .pkt_done(pkt_done),
    .pkt_len(pkt_len)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model
  int m_tip, m_tack, m_dir, m_sr, m_treq, m_set, m_done, m_plen;
  int m_cnt, m_ridx, m_rsize;
  int m_cap [16];
  int m_rep [128];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tip = 1; m_tack = 1; m_dir = 0; m_sr = 0; m_treq = 1;
      m_set = 0; m_done = 0; m_plen = 0; m_cnt = 0; m_ridx = 0; m_rsize = 0;
      foreach (m_cap[i]) m_cap[i] = 0;
      foreach (m_rep[i]) m_rep[i] = 0;
    end else begin
      int ntip, ntack, ndir, nsr;
      bit fetched;
      m_set = 0; m_done = 0; fetched = 0; nsr = 0;
      if (rep_load) begin
        m_ridx = 0;
        m_rsize = (rep_len > 128) ? 128 : rep_len;
        m_set = 1;
      end
      ntip  = pb_wr ? pb_tip_n : m_tip;
      ntack = pb_wr ? pb_tack_n : m_tack;
      ndir  = acr_wr ? acr_dir : m_dir;
      if (pb_wr || acr_wr || rep_load) begin
        if (ntip == 0) begin
          bit chg;
          chg = (ntip != m_tip) || (ntack != m_tack);
          if (ndir == 1) begin
            if (chg && m_cnt < 16) begin
              m_cap[m_cnt] = m_sr; m_cnt++; m_set = 1;
            end
          end else if (chg && m_ridx < m_rsize) begin
            nsr = m_rep[m_ridx]; m_ridx++; fetched = 1; m_set = 1;
            if (m_ridx >= m_rsize) m_treq = 1;
          end
        end else if (m_tip == 1 && ntack != m_tack) begin
          m_treq = ntack; m_set = 1;
        end else begin
          if (m_tip == 0) begin
            m_set = 1;
            if (m_cnt > 0) begin m_done = 1; m_plen = m_cnt; m_cnt = 0; end
          end
          if (m_ridx < m_rsize) m_treq = 0;
        end
        m_tip = ntip; m_tack = ntack;
      end
      m_dir = ndir;
      if (fetched) m_sr = nsr;
      else if (sr_wr) m_sr = sr_wdata;
      if (rep_wr) m_rep[rep_waddr] = rep_wdata;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 R7 R9 R11 treq_n", treq_n, m_treq);
      chk("R2 R4 R10 sr_q", sr_q, m_sr);
      chk("R2 R7 R8 R10 sr_set", sr_set, m_set);
      chk("R8 pkt_done", pkt_done, m_done);
      if (pkt_done) chk("R3 R8 pkt_len", pkt_len, m_plen);
    end
  end

  task automatic do_pb(input bit tip, input bit tack);
    @(negedge clk); pb_wr = 1; pb_tip_n = tip; pb_tack_n = tack;
    @(negedge clk); pb_wr = 0;
  endtask
  task automatic do_acr(input bit d);
    @(negedge clk); acr_wr = 1; acr_dir = d;
    @(negedge clk); acr_wr = 0;
  endtask
  task automatic do_sr(input int v);
    @(negedge clk); sr_wr = 1; sr_wdata = 8'(v);
    @(negedge clk); sr_wr = 0;
  endtask
  task automatic do_rep(input int a, input int v);
    @(negedge clk); rep_wr = 1; rep_waddr = 7'(a); rep_wdata = 8'(v);
    @(negedge clk); rep_wr = 0;
  endtask
  task automatic do_load(input int n);
    @(negedge clk); rep_load = 1; rep_len = 8'(n);
    @(negedge clk); rep_load = 0;
  endtask
  task automatic rd_cap(input int a, input int exp, input string tag);
    cap_raddr = 4'(a); #1;
    chk(tag, cap_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    bit k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 treq_n", treq_n, 1);
    chk("R1 sr_q", sr_q, 0);
    chk("R1 sr_set", sr_set, 0);
    chk("R1 pkt_done", pkt_done, 0);

    // host sends three bytes
    do_acr(1);
    k = 1;
    for (int i = 0; i < 3; i++) begin
      do_sr(8'h30 + i);
      if (i > 0) k = !k;
      do_pb(0, k);
      chk("R2 step event", sr_set, 1);
    end
    do_pb(0, k);
    chk("R6 unchanged pair", sr_set, 0);
    do_pb(1, k);
    chk("R8 done", pkt_done, 1);
    chk("R8 len", pkt_len, 3);
    chk("R8 event", sr_set, 1);
    for (int i = 0; i < 3; i++) rd_cap(i, 8'h30 + i, "R2 captured byte");

    // overflow past capture depth
    for (int i = 0; i < 20; i++) begin
      do_sr(8'h80 + i);
      if (i > 0) k = !k;
      do_pb(0, k);
      if (i == 16) chk("R3 no event when full", sr_set, 0);
    end
    do_pb(1, k);
    chk("R3 len at depth", pkt_len, 16);
    rd_cap(15, 8'h8F, "R3 last slot");
    rd_cap(0, 8'h80, "R8 capture restarted at slot 0");

    // host receives four bytes
    do_acr(0);
    for (int i = 0; i < 4; i++) do_rep(i, 8'hA0 + i);
    do_load(4);
    chk("R10 load event", sr_set, 1);
    chk("R9 request pending", treq_n, 0);
    for (int i = 0; i < 4; i++) begin
      if (i > 0) k = !k;
      do_pb(0, k);
      chk("R4 reply byte", sr_q, 8'hA0 + i);
      chk("R5 request level", treq_n, (i == 3) ? 1 : 0);
    end
    do_pb(1, k);
    chk("R8 event on rise", sr_set, 1);
    chk("R8 no packet", pkt_done, 0);

    // idle acknowledge echo
    k = !k; do_pb(1, k);
    chk("R7 echo", treq_n, k);
    chk("R7 event", sr_set, 1);
    k = !k; do_pb(1, k);
    chk("R7 echo back", treq_n, k);

    // direction write re-evaluates idle request
    do_rep(0, 8'h55);
    do_load(2);
    chk("R9 pending again", treq_n, 0);
    k = !k; do_pb(1, k);
    if (!k) begin k = 1; do_pb(1, k); end
    chk("R7 echo high", treq_n, 1);
    do_acr(0);
    chk("R11 direction write", treq_n, 0);

    // reload restarts the read index
    k = !k; do_pb(0, k);
    chk("R4 first byte", sr_q, 8'h55);
    do_pb(1, k);
    do_load(2);
    k = !k; do_pb(0, k);
    chk("R10 index restarted", sr_q, 8'h55);
    do_pb(1, k);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule